// File: doc/BRIEF.md
# Row-Repairing Memory Wrapper

This block sits in front of a row-organized storage array. The array has a few spare rows in addition to the rows that the request port can reach. A small bank of repair registers, loaded through a separate programming port, lists the visible rows that are known to be faulty. Each register is tied to one spare row. When a visible row is marked faulty, every access to that row goes to its spare row instead. The requester sees a memory of fixed size with no defects. It does not need to know how many spares exist or which rows were moved.

The row is compared against the repair registers in the same cycle as the access. A repaired row therefore answers with the same latency as an ordinary row. The repair registers accept writes only while a programming enable is high. A lock input freezes them until the next reset, so the repair map cannot be changed once the system has set it up.

Top module: `spare_row_mem`

## Requirements
- R1: After reset, no repair entry is valid, `rsp_valid` is 0, and every visible address maps directly to its own row.
- R2: Every request gets `rsp_valid` high for exactly one cycle, in the cycle after the request, whether the row is repaired or not. Read data is presented in that same cycle.
- R3: Seen from the request port, the memory returns the last value written to each visible address, whatever repair entries are programmed. The address is split as `req_addr = {row, col}`, with the row in the upper bits.
- R4: While entry k is valid and holds row r, every access to row r goes to spare row k. The normal storage of row r is not touched.
- R5: Repair replaces the whole row: every column of a repaired row moves together to the same spare row.
- R6: When two valid entries hold the same row, the entry with the lowest number is used.
- R7: A repair entry changes only when `fuse_we` and `fuse_prog_en` are both high at a clock edge. On that edge it loads `fuse_valid` and `fuse_row` into the entry selected by `fuse_sel`. An entry whose valid bit is 0 has no effect on any access.
- R8: A clock edge with `fuse_lock` high locks the repair entries. While locked, all programming writes are ignored, even after `fuse_lock` falls. Only reset clears the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (6) | Visible address {row, col} |
| req_wdata | input | DATA_W (8) | Write data |
| rsp_valid | output | 1 | Access done, one cycle after the request |
| rsp_rdata | output | DATA_W (8) | Read data |
| fuse_prog_en | input | 1 | Programming enable for repair entries |
| fuse_lock | input | 1 | Lock repair entries until reset |
| fuse_we | input | 1 | Repair entry write strobe |
| fuse_sel | input | SEL_W (2) | Repair entry index |
| fuse_valid | input | 1 | Valid bit to store |
| fuse_row | input | ROW_W (4) | Faulty row number to store |

## Verification
The bench first sweeps every visible address with no repairs. It then runs the same sweep with repairs active and locked, so that a wrong spare index or a broken column path shows up as data that does not match. To prove that traffic was steered, it invalidates an entry and reads the normal row, which must still hold its old value. It makes two entries name the same row and clears the lower one, which exposes a design that picks the higher-numbered entry. It preloads a spare and then attempts programming writes with the enable low, and again after locking. A design that failed to ignore those writes would return the spare's value instead of the normal row's.

// File: rtl/srm_pkg.sv
package srm_pkg;
    typedef enum logic [1:0] {
        SRM_IDLE  = 2'd0,
        SRM_READ  = 2'd1,
        SRM_WRITE = 2'd2
    } srm_op_e;
endpackage

// File: rtl/srm_fuse_bank.sv
module srm_fuse_bank #(
    parameter int unsigned SPARES = 4,
    parameter int unsigned ROW_W  = 4,
    localparam int unsigned SEL_W = (SPARES > 1) ? $clog2(SPARES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          prog_en_i,
    input  logic                          lock_i,
    input  logic                          we_i,
    input  logic [SEL_W-1:0]              sel_i,
    input  logic                          valid_i,
    input  logic [ROW_W-1:0]              row_i,
    output logic [SPARES-1:0]             vld_o,
    output logic [SPARES-1:0][ROW_W-1:0]  row_o
);
    typedef struct packed {
        logic                         locked;
        logic [SPARES-1:0]            vld;
        logic [SPARES-1:0][ROW_W-1:0] row;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lock_i) begin
            st_d.locked = 1'b1;
        end
        if (we_i && prog_en_i && !st_q.locked && (32'(sel_i) < SPARES)) begin
            st_d.vld[sel_i] = valid_i;
            st_d.row[sel_i] = row_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o = st_q.vld;
    assign row_o = st_q.row;

    // R8: lock stays set until reset
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> st_q.locked);
    // R8: entries frozen while locked
    p_locked_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked |=> ($stable(st_q.vld) && $stable(st_q.row)));
    // R7: no change without programming enable
    p_noprog_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en_i |=> ($stable(st_q.vld) && $stable(st_q.row)));
endmodule

// File: rtl/srm_remap.sv
module srm_remap #(
    parameter int unsigned ROWS   = 16,
    parameter int unsigned SPARES = 4,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned PROW_W = $clog2(ROWS + SPARES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid_i,
    input  logic [ROW_W-1:0]              req_row_i,
    input  logic [SPARES-1:0]             fuse_vld_i,
    input  logic [SPARES-1:0][ROW_W-1:0]  fuse_row_i,
    output logic [PROW_W-1:0]             phys_row_o,
    output logic                          hit_o
);
    logic [SPARES-1:0] match;
    logic [SPARES-1:0] grant;

    for (genvar k = 0; k < SPARES; k++) begin : g_cmp
        assign match[k] = fuse_vld_i[k] && (fuse_row_i[k] == req_row_i);
    end

    always_comb begin
        grant      = '0;
        hit_o      = 1'b0;
        phys_row_o = PROW_W'(req_row_i);
        for (int k = SPARES - 1; k >= 0; k--) begin
            if (match[k]) begin
                grant      = '0;
                grant[k]   = 1'b1;
                hit_o      = 1'b1;
                phys_row_o = PROW_W'(ROWS + k);
            end
        end
    end

    // R6: at most one spare is chosen per access
    p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |-> $onehot0(grant));
    // R4: a repaired row always lands beyond the visible rows
    p_spare_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && hit_o) |-> (32'(phys_row_o) >= ROWS));
    // R4: an unrepaired row stays inside the visible rows
    p_normal_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !hit_o) |-> (32'(phys_row_o) < ROWS));
endmodule

// File: rtl/srm_array.sv
module srm_array #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PROWS  = 20,
    parameter int unsigned COLS   = 4,
    localparam int unsigned PROW_W = $clog2(PROWS),
    localparam int unsigned COL_W  = $clog2(COLS),
    localparam int unsigned DEPTH  = PROWS * COLS,
    localparam int unsigned IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  srm_pkg::srm_op_e  op_i,
    input  logic [PROW_W-1:0] prow_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rdata_o
);
    import srm_pkg::*;

    typedef struct packed {
        logic              rsp_valid;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx;
    rsp_t              rs_d, rs_q;

    assign idx = IDX_W'(32'(prow_i) * COLS + 32'(col_i));

    always_comb begin
        rs_d           = rs_q;
        rs_d.rsp_valid = (op_i != SRM_IDLE);
        if (op_i == SRM_READ) begin
            rs_d.rdata = mem[idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    always_ff @(posedge clk) begin
        if (op_i == SRM_WRITE) begin
            mem[idx] <= wdata_i;
        end
    end

    assign rsp_valid_o = rs_q.rsp_valid;
    assign rdata_o     = rs_q.rdata;

    // R2: every access is answered on the next cycle
    p_rsp_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != SRM_IDLE) |=> rsp_valid_o);
    // R2: no response without an access
    p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SRM_IDLE) |=> !rsp_valid_o);
endmodule

// File: rtl/spare_row_mem.sv
module spare_row_mem #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ROWS   = 16,
    parameter int unsigned COLS   = 4,
    parameter int unsigned SPARES = 4,
    localparam int unsigned ROW_W  = $clog2(ROWS),
    localparam int unsigned COL_W  = $clog2(COLS),
    localparam int unsigned ADDR_W = ROW_W + COL_W,
    localparam int unsigned PROWS  = ROWS + SPARES,
    localparam int unsigned PROW_W = $clog2(PROWS),
    localparam int unsigned SEL_W  = (SPARES > 1) ? $clog2(SPARES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              fuse_prog_en,
    input  logic              fuse_lock,
    input  logic              fuse_we,
    input  logic [SEL_W-1:0]  fuse_sel,
    input  logic              fuse_valid,
    input  logic [ROW_W-1:0]  fuse_row
);
    import srm_pkg::*;

    logic [SPARES-1:0]            f_vld;
    logic [SPARES-1:0][ROW_W-1:0] f_row;
    logic [ROW_W-1:0]             v_row;
    logic [COL_W-1:0]             v_col;
    logic [PROW_W-1:0]            p_row;
    logic                         hit;
    srm_op_e                      op;

    assign v_row = req_addr[ADDR_W-1:COL_W];
    assign v_col = req_addr[COL_W-1:0];

    always_comb begin
        op = SRM_IDLE;
        if (req_valid) begin
            op = req_write ? SRM_WRITE : SRM_READ;
        end
    end

    srm_fuse_bank #(.SPARES(SPARES), .ROW_W(ROW_W)) i_fuse (
        .clk(clk), .rst_n(rst_n), .prog_en_i(fuse_prog_en), .lock_i(fuse_lock),
        .we_i(fuse_we), .sel_i(fuse_sel), .valid_i(fuse_valid), .row_i(fuse_row),
        .vld_o(f_vld), .row_o(f_row)
    );

    srm_remap #(.ROWS(ROWS), .SPARES(SPARES)) i_remap (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_row_i(v_row),
        .fuse_vld_i(f_vld), .fuse_row_i(f_row), .phys_row_o(p_row), .hit_o(hit)
    );

    srm_array #(.DATA_W(DATA_W), .PROWS(PROWS), .COLS(COLS)) i_array (
        .clk(clk), .rst_n(rst_n), .op_i(op), .prow_i(p_row), .col_i(v_col),
        .wdata_i(req_wdata), .rsp_valid_o(rsp_valid), .rdata_o(rsp_rdata)
    );

    // R1: nothing is repaired in the cycle after reset ends
    p_clean_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (f_vld == '0));
endmodule

// File: tb/test_spare_row_mem.sv
module test_spare_row_mem;
    localparam int CLK_PERIOD = 10;
    localparam int COLS = 4;
    localparam int ROWS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0;
    logic [5:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic [7:0] rsp_rdata;
    logic       fuse_prog_en = 1'b0, fuse_lock = 1'b0, fuse_we = 1'b0, fuse_valid = 1'b0;
    logic [1:0] fuse_sel = '0;
    logic [3:0] fuse_row = '0;

    int n_checks = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spare_row_mem i_spare_row_mem (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .fuse_prog_en(fuse_prog_en), .fuse_lock(fuse_lock),
        .fuse_we(fuse_we), .fuse_sel(fuse_sel), .fuse_valid(fuse_valid), .fuse_row(fuse_row)
    );

    function automatic logic [7:0] pat(input int a, input int seed);
        return 8'(((a * 37) + (seed * 11)) ^ 8'h5A);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 6'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(rsp_valid == 1'b1, "R2 write done", int'(rsp_valid), 1);
    endtask

    task automatic rd(input int a, input logic [7:0] exp, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 6'(a);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, "R2 read done", int'(rsp_valid), 1);
        chk(rsp_rdata == exp, req, int'(rsp_rdata), int'(exp));
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R2 single pulse", int'(rsp_valid), 0);
    endtask

    task automatic fz(input int idx, input bit v, input int row, input bit en);
        @(negedge clk);
        fuse_we = 1'b1; fuse_sel = 2'(idx); fuse_valid = v; fuse_row = 4'(row); fuse_prog_en = en;
        @(negedge clk);
        fuse_we = 1'b0; fuse_prog_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", int'(rsp_valid), 0);
        chk(rsp_rdata == 8'h00, "R1 reset rdata", int'(rsp_rdata), 0);

        // R1 direct sweep, no repairs
        for (int a = 0; a < ROWS * COLS; a++) wr(a, pat(a, 1));
        for (int a = 0; a < ROWS * COLS; a++) rd(a, pat(a, 1), "R1 direct map");

        // R4/R5: entry 2 repairs row 5, whole row moves
        fz(2, 1'b1, 5, 1'b1);
        for (int c = 0; c < COLS; c++) wr(5 * COLS + c, pat(5 * COLS + c, 2));
        for (int c = 0; c < COLS; c++) rd(5 * COLS + c, pat(5 * COLS + c, 2), "R5 repaired row cols");
        rd(4 * COLS + 1, pat(4 * COLS + 1, 1), "R4 neighbour row 4 untouched");
        rd(6 * COLS + 2, pat(6 * COLS + 2, 1), "R4 neighbour row 6 untouched");
        fz(2, 1'b0, 5, 1'b1);
        for (int c = 0; c < COLS; c++) rd(5 * COLS + c, pat(5 * COLS + c, 1), "R4 normal row kept old data");

        // R6: entries 0 and 1 both on row 9
        fz(1, 1'b1, 9, 1'b1);
        wr(9 * COLS, 8'hB1);
        fz(0, 1'b1, 9, 1'b1);
        wr(9 * COLS, 8'hA0);
        rd(9 * COLS, 8'hA0, "R6 duplicate read");
        fz(0, 1'b0, 9, 1'b1);
        rd(9 * COLS, 8'hB1, "R6 higher entry untouched by lower-wins write");
        fz(1, 1'b0, 9, 1'b1);
        rd(9 * COLS, pat(9 * COLS, 1), "R7 invalid entries have no effect");

        // R7: preload spare 3 via row 2, then try programming with enable low
        fz(3, 1'b1, 2, 1'b1);
        wr(2 * COLS, 8'h33);
        fz(3, 1'b0, 2, 1'b1);
        fz(3, 1'b1, 2, 1'b0);
        rd(2 * COLS, pat(2 * COLS, 1), "R7 write without enable ignored");

        // R8: program, lock, then try to clear
        fz(3, 1'b1, 2, 1'b1);
        fz(0, 1'b1, 15, 1'b1);
        @(negedge clk); fuse_lock = 1'b1;
        @(negedge clk); fuse_lock = 1'b0;
        fz(3, 1'b0, 2, 1'b1);
        rd(2 * COLS, 8'h33, "R8 locked entry kept");
        fz(1, 1'b1, 7, 1'b1);
        rd(7 * COLS + 3, pat(7 * COLS + 3, 1), "R8 locked new entry rejected");

        // R3 full sweep with repairs locked
        for (int a = 0; a < ROWS * COLS; a++) wr(a, pat(a, 7));
        for (int a = 0; a < ROWS * COLS; a++) rd(a, pat(a, 7), "R3 perfect memory with repairs");

        // R1/R8: reset clears entries and lock
        do_reset();
        rd(2 * COLS, pat(2 * COLS, 1), "R1 reset clears repair row 2");
        rd(15 * COLS + 1, pat(15 * COLS + 1, 1), "R1 reset clears repair row 15");
        rd(3 * COLS, pat(3 * COLS, 7), "R1 unrepaired row after reset");
        fz(1, 1'b1, 3, 1'b1);
        wr(3 * COLS, 8'h55);
        rd(3 * COLS, 8'h55, "R8 programming works after reset");
        fz(1, 1'b0, 3, 1'b1);
        rd(3 * COLS, pat(3 * COLS, 7), "R4 normal row after unlock test");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule